// File: doc/BRIEF.md
# Indirect Configuration Register Port

This block is the software-facing register front end of a two-channel disk host controller. The host sees a four-byte I/O window, and most of the configuration sits behind it. Software first writes a pointer byte that names a channel and an index. It then moves words through a data port. Each channel owns a bank of seven configuration entries: command-block base, control-block base, a general control byte, two read-ahead setup entries and two timing bytes. The decoded fields drive the channel's disk-bus timing and DMA logic, which are outside this block.

The window holds two more byte registers. At offset 2, a read returns the primary channel's interrupt status, and a guarded write sets test and compatibility controls. At offset 3 sit the per-channel interrupt masks, the secondary channel's status and a board-level legacy flag. The block also combines each channel's status inputs with its mask and its programmed polarity to form that channel's interrupt line. A host access lasts one clock. Read data is combinational from the current state, and every write or pointer advance takes effect at the clock edge that ends the access.

Top module: `cfgwin_top`

## Requirements
- R1: After reset, the primary bank holds index 0 = 0x01F0, index 4 = 0x03F6, index 5 = 0xF5, index 6 = 0xDE and index 1 = 0x01. The secondary bank is the same except index 0 = 0x0170 and index 4 = 0x0376. Indices 2 and 3, both interrupt masks and the test controls reset to zero.
- R2: Offset 1 holds the pointer byte, which reads back as written. Pointer bit 3 picks the bank (0 primary, 1 secondary) and bits 2-0 pick the index. A data-port access at offset 0 reaches only the selected entry of the selected bank.
- R3: When pointer bit 7 is set, every data-port read or write advances pointer bits 2-0 by one, and index 6 (or 7) wraps to 0. Bits 7-3 never change this way. With bit 7 clear, the pointer does not move.
- R4: Index 7 reads as zero, and a write to it changes no configuration output.
- R5: Indices 2 and 3 read as zero. The 10-bit read-ahead count is {index 3 bits 1-0, index 2 bits 7-0}. Index 3 bit 7 is the read-ahead enable and bit 4 is the fast-timing enable.
- R6: A data-port write to index 3 with bit 6 set raises that channel's FIFO-clear output for exactly the one cycle after the write. The bit is not stored.
- R7: A read at offset 2 returns {14'b0, primary bus-master interrupt, primary drive interrupt}.
- R8: A write at offset 2 with bit 7 set loads test mode from bit 0 and compatibility mode from bit 1. A write there with bit 7 clear is ignored.
- R9: A write at offset 3 loads the masks from bits 1-0 (bit 0 primary, 1 = masked). A read at offset 3 returns the legacy flag in bit 4, secondary bus-master status in bit 3, secondary drive status in bit 2 and the masks in bits 1-0.
- R10: A channel's interrupt output is (drive status OR bus-master status) AND NOT mask. It is inverted when bit 3 of that channel's index 1 is set (active low).
- R11: Byte-wide entries (indices 1, 2, 3, 5, 6) take the low byte of the data-port word. Word entries (indices 0 and 4) take all 16 bits. Byte entries read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Window offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data (byte registers use bits 7-0) |
| bus_rdata | output | 16 | Read data for the addressed offset |
| drv_irq_i | input | 2 | Per-channel drive interrupt status |
| bm_irq_i | input | 2 | Per-channel bus-master interrupt status |
| legacy_hdr_i | input | 1 | Legacy-header presence flag |
| cmd_base_o | output | 2x16 | Command-block base per channel |
| ctl_base_o | output | 2x16 | Control-block base per channel |
| dev_cfg_o | output | 2x8 | General control byte per channel |
| ra_count_o | output | 2x10 | Read-ahead count per channel |
| ra_en_o | output | 2 | Read-ahead enable per channel |
| mode4_o | output | 2 | Fast-timing enable per channel |
| data_tim_o | output | 2x8 | Data-port timing byte per channel |
| cmd_tim_o | output | 2x8 | Command-port timing byte per channel |
| fifo_clr_o | output | 2 | One-cycle FIFO-clear pulse per channel |
| test_mode_o | output | 1 | Test mode control |
| compat_o | output | 1 | Compatibility mode control |
| irq_o | output | 2 | Per-channel interrupt output |

## Verification
The bench walks each bank with auto-increment on and reads all seven entries plus the wrap back to index 0. This separates a bank-select error, an off-by-one or missing wrap, and wrong reset values in one pass. Writes are made both with and without auto-increment, to the other bank and to index 7. Reading the pointer and the outputs of both banks afterwards shows whether an access leaked to another entry or moved the pointer when it should not. Status inputs are set one pattern at a time against both masks and both polarities, so that crossed channels, a swapped bit inside the offset 2 and 3 reads, and an inverted polarity each produce a visibly different value.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int NUM_CH   = 2;
    localparam int IDX_W    = 3;
    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int RA_W     = 10;
    localparam int RA_HI_W  = RA_W - BYTE_W;

    localparam logic [IDX_W-1:0] IX_CMD_BASE = 3'd0;
    localparam logic [IDX_W-1:0] IX_DEV_CFG  = 3'd1;
    localparam logic [IDX_W-1:0] IX_RA_LO    = 3'd2;
    localparam logic [IDX_W-1:0] IX_RA_CTL   = 3'd3;
    localparam logic [IDX_W-1:0] IX_CTL_BASE = 3'd4;
    localparam logic [IDX_W-1:0] IX_DAT_TIM  = 3'd5;
    localparam logic [IDX_W-1:0] IX_CMD_TIM  = 3'd6;
    localparam logic [IDX_W-1:0] IX_LAST     = IX_CMD_TIM;

    // window offsets
    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_PTR  = 2'd1;
    localparam logic [1:0] OFS_TEST = 2'd2;
    localparam logic [1:0] OFS_MASK = 2'd3;

    typedef struct packed {
        logic [WORD_W-1:0]  cmd_base;
        logic [BYTE_W-1:0]  dev_cfg;
        logic [BYTE_W-1:0]  ra_lo;
        logic               ra_en;
        logic               mode4;
        logic [RA_HI_W-1:0] ra_hi;
        logic [WORD_W-1:0]  ctl_base;
        logic [BYTE_W-1:0]  data_tim;
        logic [BYTE_W-1:0]  cmd_tim;
    } bank_t;

    function automatic bank_t bank_reset(input logic secondary);
        bank_t b;
        b.cmd_base = secondary ? 16'h0170 : 16'h01F0;
        b.dev_cfg  = 8'h01;
        b.ra_lo    = '0;
        b.ra_en    = 1'b0;
        b.mode4    = 1'b0;
        b.ra_hi    = '0;
        b.ctl_base = secondary ? 16'h0376 : 16'h03F6;
        b.data_tim = 8'hF5;
        b.cmd_tim  = 8'hDE;
        return b;
    endfunction

endpackage

// File: rtl/cfgwin_bank.sv
module cfgwin_bank
    import cfgwin_pkg::*;
#(
    parameter bit SECONDARY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output bank_t             cfg,
    output logic [WORD_W-1:0] rdata,
    output logic              fifo_clr
);

    typedef struct packed {
        bank_t regs;
        logic  fifo_clr;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.fifo_clr = 1'b0;
        if (wr_en) begin
            case (idx)
                IX_CMD_BASE: st_d.regs.cmd_base = wdata;
                IX_DEV_CFG:  st_d.regs.dev_cfg  = wdata[BYTE_W-1:0];
                IX_RA_LO:    st_d.regs.ra_lo    = wdata[BYTE_W-1:0];
                IX_RA_CTL: begin
                    st_d.regs.ra_en = wdata[7];
                    st_d.regs.mode4 = wdata[4];
                    st_d.regs.ra_hi = wdata[RA_HI_W-1:0];
                    st_d.fifo_clr   = wdata[6];
                end
                IX_CTL_BASE: st_d.regs.ctl_base = wdata;
                IX_DAT_TIM:  st_d.regs.data_tim = wdata[BYTE_W-1:0];
                IX_CMD_TIM:  st_d.regs.cmd_tim  = wdata[BYTE_W-1:0];
                default:     st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.regs     <= bank_reset(SECONDARY);
            st_q.fifo_clr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (idx)
            IX_CMD_BASE: rdata = st_q.regs.cmd_base;
            IX_DEV_CFG:  rdata = {{(WORD_W-BYTE_W){1'b0}}, st_q.regs.dev_cfg};
            IX_CTL_BASE: rdata = st_q.regs.ctl_base;
            IX_DAT_TIM:  rdata = {{(WORD_W-BYTE_W){1'b0}}, st_q.regs.data_tim};
            IX_CMD_TIM:  rdata = {{(WORD_W-BYTE_W){1'b0}}, st_q.regs.cmd_tim};
            default:     rdata = '0;
        endcase
    end

    assign cfg      = st_q.regs;
    assign fifo_clr = st_q.fifo_clr;

endmodule

// File: rtl/cfgwin_irq.sv
module cfgwin_irq (
    input  logic drv_stat,
    input  logic bm_stat,
    input  logic masked,
    input  logic active_low,
    output logic irq
);

    logic raw_d;

    always_comb begin
        raw_d = (drv_stat | bm_stat) & ~masked;
        irq   = raw_d ^ active_low;
    end

endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
    import cfgwin_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     bus_addr,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [15:0]                    bus_wdata,
    output logic [15:0]                    bus_rdata,
    input  logic [1:0]                     drv_irq_i,
    input  logic [1:0]                     bm_irq_i,
    input  logic                           legacy_hdr_i,
    output logic [1:0][15:0]               cmd_base_o,
    output logic [1:0][15:0]               ctl_base_o,
    output logic [1:0][7:0]                dev_cfg_o,
    output logic [1:0][9:0]                ra_count_o,
    output logic [1:0]                     ra_en_o,
    output logic [1:0]                     mode4_o,
    output logic [1:0][7:0]                data_tim_o,
    output logic [1:0][7:0]                cmd_tim_o,
    output logic [1:0]                     fifo_clr_o,
    output logic                           test_mode_o,
    output logic                           compat_o,
    output logic [1:0]                     irq_o
);

    localparam int CH_BIT  = IDX_W;     // pointer bit picking the bank
    localparam int INC_BIT = 7;         // pointer bit enabling advance
    localparam int GUARD_BIT = 7;       // offset 2 write qualifier

    typedef struct packed {
        logic [BYTE_W-1:0] ptr;
        logic              test_mode;
        logic              compat;
        logic [NUM_CH-1:0] mask;
    } win_st_t;

    win_st_t st_d, st_q;

    logic                         data_acc;
    logic [NUM_CH-1:0]            bank_wr;
    logic [NUM_CH-1:0][WORD_W-1:0] bank_rd;
    logic [IDX_W-1:0]             cur_idx;
    logic                         cur_ch;
    logic [BYTE_W-1:0]            ptr_q;
    logic [NUM_CH-1:0]            mask_q;

    assign cur_idx = st_q.ptr[IDX_W-1:0];
    assign cur_ch  = st_q.ptr[CH_BIT];
    assign ptr_q   = st_q.ptr;
    assign mask_q  = st_q.mask;
    assign data_acc = (bus_wr | bus_rd) && (bus_addr == OFS_DATA);

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (bus_addr)
                OFS_PTR: st_d.ptr = bus_wdata[BYTE_W-1:0];
                OFS_TEST: begin
                    if (bus_wdata[GUARD_BIT]) begin
                        st_d.test_mode = bus_wdata[0];
                        st_d.compat    = bus_wdata[1];
                    end
                end
                OFS_MASK: st_d.mask = bus_wdata[NUM_CH-1:0];
                default: ;
            endcase
        end
        if (data_acc && st_q.ptr[INC_BIT]) begin
            if (cur_idx >= IX_LAST)
                st_d.ptr[IDX_W-1:0] = '0;
            else
                st_d.ptr[IDX_W-1:0] = cur_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_DATA: bus_rdata = bank_rd[cur_ch];
            OFS_PTR:  bus_rdata = {{(WORD_W-BYTE_W){1'b0}}, st_q.ptr};
            OFS_TEST: bus_rdata = {{(WORD_W-2){1'b0}}, bm_irq_i[0], drv_irq_i[0]};
            default:  bus_rdata = {{(WORD_W-5){1'b0}}, legacy_hdr_i,
                                   bm_irq_i[1], drv_irq_i[1], st_q.mask};
        endcase
    end

    assign test_mode_o = st_q.test_mode;
    assign compat_o    = st_q.compat;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bank_t cfg_c;

        assign bank_wr[c] = bus_wr && (bus_addr == OFS_DATA) && (cur_ch == c[0]);

        cfgwin_bank #(.SECONDARY(c == 1)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr[c]),
            .idx      (cur_idx),
            .wdata    (bus_wdata),
            .cfg      (cfg_c),
            .rdata    (bank_rd[c]),
            .fifo_clr (fifo_clr_o[c])
        );

        cfgwin_irq u_irq (
            .drv_stat   (drv_irq_i[c]),
            .bm_stat    (bm_irq_i[c]),
            .masked     (st_q.mask[c]),
            .active_low (cfg_c.dev_cfg[3]),
            .irq        (irq_o[c])
        );

        assign cmd_base_o[c] = cfg_c.cmd_base;
        assign ctl_base_o[c] = cfg_c.ctl_base;
        assign dev_cfg_o[c]  = cfg_c.dev_cfg;
        assign ra_count_o[c] = {cfg_c.ra_hi, cfg_c.ra_lo};
        assign ra_en_o[c]    = cfg_c.ra_en;
        assign mode4_o[c]    = cfg_c.mode4;
        assign data_tim_o[c] = cfg_c.data_tim;
        assign cmd_tim_o[c]  = cfg_c.cmd_tim;
    end

endmodule

// File: rtl/cfgwin_chk.sv
module cfgwin_chk (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [15:0]      bus_wdata,
    input logic [7:0]       ptr_q,
    input logic [1:0]       mask_q,
    input logic [1:0][7:0]  dev_cfg_o,
    input logic [1:0]       fifo_clr_o,
    input logic [1:0]       irq_o,
    input logic             test_mode_o,
    input logic             compat_o
);

    logic acc;
    assign acc = (bus_wr | bus_rd) && (bus_addr == 2'd0);

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ptr_q[7] && ptr_q[2:0] == 3'd6) |=> (ptr_q[2:0] == 3'd0)); // R3

    AST_HIGH_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> $stable(ptr_q[7:3])); // R3

    AST_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ptr_q[7]) |=> $stable(ptr_q)); // R3

    AST_TEST_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && !bus_wdata[7]) |=> $stable({test_mode_o, compat_o})); // R8

    for (genvar c = 0; c < 2; c++) begin : g_c
        AST_FIFO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            fifo_clr_o[c] |-> $past(bus_wr && bus_addr == 2'd0 && ptr_q[3] == c[0]
                                    && ptr_q[2:0] == 3'd3 && bus_wdata[6])); // R6

        AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            mask_q[c] |-> (irq_o[c] == dev_cfg_o[c][3])); // R10
    end

endmodule

bind cfgwin_top cfgwin_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .ptr_q       (ptr_q),
    .mask_q      (mask_q),
    .dev_cfg_o   (dev_cfg_o),
    .fifo_clr_o  (fifo_clr_o),
    .irq_o       (irq_o),
    .test_mode_o (test_mode_o),
    .compat_o    (compat_o)
);

// File: tb/cfgwin_top_test.sv
`timescale 1ns/1ps
module cfgwin_top_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic [1:0]        drv_irq_i = '0;
    logic [1:0]        bm_irq_i = '0;
    logic              legacy_hdr_i = 1'b1;
    logic [1:0][15:0]  cmd_base_o, ctl_base_o;
    logic [1:0][7:0]   dev_cfg_o, data_tim_o, cmd_tim_o;
    logic [1:0][9:0]   ra_count_o;
    logic [1:0]        ra_en_o, mode4_o, fifo_clr_o, irq_o;
    logic              test_mode_o, compat_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    cfgwin_top uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // every op starts just after a rising edge and returns just after the next
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // monitor: compares read data mid-cycle against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            if (bus_rd) begin
                if (exp_q.size() == 0) begin
                    n_vec++; n_bad++;
                    $display("FAIL scoreboard: unexpected read, actual 0x%0h expected none", bus_rdata);
                end else begin
                    chk(tag_q.pop_front(), {16'h0, bus_rdata}, {16'h0, exp_q.pop_front()});
                end
            end
        end
    end

    initial begin
        #1_000_000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset outputs
        chk("R1 cmd_base0", cmd_base_o[0], 16'h01F0);
        chk("R1 cmd_base1", cmd_base_o[1], 16'h0170);
        chk("R1 ctl_base1", ctl_base_o[1], 16'h0376);
        chk("R1 dev_cfg0", dev_cfg_o[0], 8'h01);
        chk("R1 test ctl", {test_mode_o, compat_o}, 2'b00);
        chk("R10 irq idle", irq_o, 2'b00);
        rd(2'd3, 16'h0010, "R1/R9 masks reset, legacy flag");

        // R1 R3 R5 walk primary bank with auto-increment
        wr(2'd1, 16'h0080);
        rd(2'd0, 16'h01F0, "R1 p idx0");
        rd(2'd0, 16'h0001, "R1 p idx1");
        rd(2'd0, 16'h0000, "R5 p idx2 write-only");
        rd(2'd0, 16'h0000, "R5 p idx3 write-only");
        rd(2'd0, 16'h03F6, "R1 p idx4");
        rd(2'd0, 16'h00F5, "R1 p idx5");
        rd(2'd0, 16'h00DE, "R1 p idx6");
        rd(2'd0, 16'h01F0, "R3 wrap to idx0");
        rd(2'd1, 16'h0081, "R3 pointer after wrap");

        // R2 secondary bank
        wr(2'd1, 16'h0088);
        rd(2'd0, 16'h0170, "R2 s idx0");
        rd(2'd0, 16'h0001, "R2 s idx1");
        rd(2'd0, 16'h0000, "R5 s idx2");
        rd(2'd0, 16'h0000, "R5 s idx3");
        rd(2'd0, 16'h0376, "R1 s idx4");
        rd(2'd0, 16'h00F5, "R1 s idx5");
        rd(2'd0, 16'h00DE, "R1 s idx6");

        // R11 byte write without increment
        wr(2'd1, 16'h0005);
        wr(2'd0, 16'h1234);
        chk("R11 data_tim0 low byte", data_tim_o[0], 8'h34);
        chk("R2 other bank untouched", data_tim_o[1], 8'hF5);
        rd(2'd0, 16'h0034, "R11 zero-extended readback");
        rd(2'd1, 16'h0005, "R3 no advance without bit7");

        // R3 R5 R6 auto-increment writes to secondary
        wr(2'd1, 16'h0088);
        wr(2'd0, 16'hABCD);
        wr(2'd0, 16'h0089);
        wr(2'd0, 16'h00FF);
        wr(2'd0, 16'h00C3);
        chk("R6 fifo pulse", fifo_clr_o, 2'b10);
        chk("R5 ra_count1", ra_count_o[1], 10'h3FF);
        chk("R5 ra_en/mode4", {ra_en_o[1], mode4_o[1]}, 2'b10);
        chk("R11 word cmd_base1", cmd_base_o[1], 16'hABCD);
        chk("R2 dev_cfg1", dev_cfg_o[1], 8'h89);
        rd(2'd1, 16'h008C, "R3 pointer after four writes");
        chk("R6 pulse ends", fifo_clr_o, 2'b00);

        // R4 index 7
        wr(2'd1, 16'h0007);
        rd(2'd0, 16'h0000, "R4 idx7 reads zero");
        wr(2'd0, 16'hFFFF);
        chk("R4 cmd_base0 kept", cmd_base_o[0], 16'h01F0);
        chk("R4 ctl_base0 kept", ctl_base_o[0], 16'h03F6);
        chk("R4 timings kept", {data_tim_o[0], cmd_tim_o[0]}, 16'h34DE);
        chk("R4 dev_cfg0/ra kept", {dev_cfg_o[0], ra_count_o[0], fifo_clr_o}, {8'h01, 10'h000, 2'b00});

        // R7 primary status
        drv_irq_i = 2'b01; bm_irq_i = 2'b10; #1;
        rd(2'd2, 16'h0001, "R7 drive only");
        chk("R10 ch0 active high", irq_o[0], 1'b1);
        chk("R10 ch1 active low asserted", irq_o[1], 1'b0);
        bm_irq_i = 2'b11; #1;
        rd(2'd2, 16'h0003, "R7 both");

        // R8 guarded test writes
        wr(2'd2, 16'h0003);
        chk("R8 ignored without bit7", {test_mode_o, compat_o}, 2'b00);
        wr(2'd2, 16'h0083);
        chk("R8 loaded", {test_mode_o, compat_o}, 2'b11);
        wr(2'd2, 16'h0001);
        chk("R8 second ignore", {test_mode_o, compat_o}, 2'b11);

        // R9 masks and secondary status
        legacy_hdr_i = 1'b0; #1;
        rd(2'd3, 16'h0008, "R9 secondary bm status");
        wr(2'd3, 16'h00FF);
        rd(2'd3, 16'h000B, "R9 masks set");
        chk("R10 masked outputs idle", irq_o, 2'b10);
        wr(2'd3, 16'h0002);
        chk("R10 ch0 unmasked", irq_o, 2'b11);
        drv_irq_i = 2'b00; bm_irq_i = 2'b00; #1;
        chk("R10 no status", irq_o, 2'b10);

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) chk("scoreboard drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule